// File: doc/BRIEF.md
# Cutset-free pipelined multiply-accumulate unit

This block accumulates a stream of unsigned products into a single running partial sum, the kind of dot-product step used by a machine-learning accelerator. On each accepted cycle it multiplies two operands and forms the partial-product rows. A column-addition tree of 4:2 compressors reduces those rows to two. The two rows go straight into the accumulator's one carry-propagate adder, so a product never passes through a separate multiplier adder of its own.

To shorten the critical path, the accumulator adder is cut in two, and only the carry out of the low half is registered. That carry enters the high half one cycle later. This is not a full feedforward cutset, so the accumulator can hold a wrong value for one cycle at a time. The sum stays exact because every carry bit is added exactly once. When the stream ends, the unit runs one flush cycle with zero operands to absorb the pending carry. It then shows the exact total for one cycle, clears itself, and accepts the next stream.

Top module: `cfmac_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the unit clears. After reset, `result_valid` is 0, `result` is 0, and the unit is ready to accept operands.
- R2: For a stream of 1 to 64 accepted operand pairs, `result` equals the sum of the products `op_a*op_b` when `result_valid` is high.
- R3: The edge that accepts a pair with `in_last` high starts a flush. `result_valid` is low in the cycle after that edge, high in the next cycle, and low again in the cycle after that. It is therefore a single-cycle pulse.
- R4: A cycle with `in_valid` low adds nothing to the sum, whatever values `op_a` and `op_b` carry.
- R5: The sum wraps modulo 2^24. Any part of the total at or above 2^24 is discarded.
- R6: The registered carry between the low and high 12-bit halves of the accumulator is absorbed before the result is shown. Long runs of all-ones operands, which carry across that boundary on most cycles, still give the exact total.
- R7: The accumulator clears in the cycle `result_valid` is high. A pair presented in the following cycle is the first term of a new sum that starts from zero.
- R8: Operands presented during the flush cycle or during the `result_valid` cycle are ignored, even with `in_valid` and `in_last` high.
- R9: `in_last` has no effect while `in_valid` is low. It neither ends the stream nor raises `result_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset and clear |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| in_last | input | 1 | Marks the final pair of a stream; counts only with `in_valid` high |
| result | output | 24 | Accumulated sum; exact only while `result_valid` is high |
| result_valid | output | 1 | One-cycle pulse marking the exact total |

## Verification
The only state that can go wrong without showing at once is the pending inter-half carry and the accumulator beneath it. A lost or doubled carry changes the total by a multiple of 4096, and it stays hidden until the next `result_valid` pulse. That pulse comes two cycles after the stream's last pair. Streams of all-ones operands and streams padded with idle cycles drive carries across the boundary on many cycles, so such an error shows at the first result. A control fault, such as a wrong flush length, an uncleared sum or a stray `in_last` being honoured, shows within three cycles as a misplaced pulse or a wrong first result of the next stream.

// File: rtl/cfmac_pkg.sv
// Shared sizes and control encoding for the cutset-free MAC.
// Assumes OP_W is a power of two of at least 4 and ACC_W >= 2*OP_W.
package cfmac_pkg;
    localparam int OP_W  = 8;
    localparam int ACC_W = 24;
    localparam int LO_W  = 12;

    typedef enum logic [1:0] {
        ST_ACC   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DONE  = 2'd2
    } cf_state_e;
endpackage

// File: rtl/cfmac_ppgen.sv
// Partial-product generator: row i is op_a shifted left by i, kept only
// where bit i of op_b is set. Rows are zero-extended to the accumulator width.
module cfmac_ppgen #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 24
) (
    input  logic [OP_W-1:0]             a,
    input  logic [OP_W-1:0]             b,
    output logic [OP_W-1:0][ACC_W-1:0]  pp
);
    // form each AND-gated, shifted row
    always_comb begin
        for (int i = 0; i < OP_W; i++) begin
            pp[i] = b[i] ? (ACC_W'(a) << i) : '0;
        end
    end
endmodule

// File: rtl/cfmac_comp42_row.sv
// One row of 4:2 compressors. It turns four addends into a sum row and a
// carry row (already weighted by two) with the same total modulo 2^W.
// The lateral carry runs one bit to the left, and its top bit drops out.
module cfmac_comp42_row #(
    parameter int W = 24
) (
    input  logic [W-1:0] x0,
    input  logic [W-1:0] x1,
    input  logic [W-1:0] x2,
    input  logic [W-1:0] x3,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    logic [W-1:0] t;
    logic [W-1:0] lat;

    // per-bit compressor cells
    always_comb begin
        lat[0] = 1'b0;
        c[0]   = 1'b0;
        for (int i = 0; i < W; i++) begin
            t[i] = x0[i] ^ x1[i] ^ x2[i];
            s[i] = t[i] ^ x3[i] ^ lat[i];
            if (i < W-1) begin
                lat[i+1] = (x0[i] & x1[i]) | (x0[i] & x2[i]) | (x1[i] & x2[i]);
                c[i+1]   = (t[i] & x3[i]) | (t[i] & lat[i]) | (x3[i] & lat[i]);
            end
        end
    end
endmodule

// File: rtl/cfmac_tree.sv
// Column-addition tree: halves the row count on each level with 4:2
// compressor rows until two rows remain. Assumes OP_W is a power of two >= 4.
module cfmac_tree #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 24
) (
    input  logic [OP_W-1:0][ACC_W-1:0] pp,
    output logic [ACC_W-1:0]           row_s,
    output logic [ACC_W-1:0]           row_c
);
    localparam int LVLS = $clog2(OP_W) - 1;

    wire [ACC_W-1:0] rows [LVLS+1][OP_W];

    for (genvar i = 0; i < OP_W; i++) begin : g_in
        assign rows[0][i] = pp[i];
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        localparam int NOUT = OP_W >> (l + 1);
        for (genvar g = 0; g < NOUT/2; g++) begin : g_cmp
            cfmac_comp42_row #(.W(ACC_W)) u_row (
                .x0 (rows[l][4*g]),
                .x1 (rows[l][4*g+1]),
                .x2 (rows[l][4*g+2]),
                .x3 (rows[l][4*g+3]),
                .s  (rows[l+1][2*g]),
                .c  (rows[l+1][2*g+1])
            );
        end
        for (genvar j = NOUT; j < OP_W; j++) begin : g_pad
            assign rows[l+1][j] = '0;
        end
    end

    assign row_s = rows[LVLS][0];
    assign row_c = rows[LVLS][1];
endmodule

// File: rtl/cfmac_split_acc.sv
// Accumulator with merged addition. A 3:2 stage folds the two tree rows into
// the stored sum. The carry-propagate adder is split at LO_W: the carry out of
// the low half goes into a register and enters the high half on the next
// cycle. The stored sum plus pend_q*2^LO_W always equals the true total.
module cfmac_split_acc #(
    parameter int ACC_W = 24,
    parameter int LO_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] row_s,
    input  logic [ACC_W-1:0] row_c,
    output logic [ACC_W-1:0] acc_q,
    output logic             pend_q
);
    localparam int HI_W = ACC_W - LO_W;

    logic [ACC_W-1:0] s3, c3;
    logic [ACC_W-2:0] mj;
    logic [LO_W:0]    lo_sum;
    logic [HI_W-1:0]  hi_sum;

    // 3:2 merge of the stored sum with both tree rows
    always_comb begin
        s3 = acc_q ^ row_s ^ row_c;
        mj = (acc_q[ACC_W-2:0] & row_s[ACC_W-2:0]) |
             (acc_q[ACC_W-2:0] & row_c[ACC_W-2:0]) |
             (row_s[ACC_W-2:0] & row_c[ACC_W-2:0]);
        c3 = {mj, 1'b0};
    end

    // split carry-propagate adder; the high half takes last cycle's carry
    always_comb begin
        lo_sum = {1'b0, s3[LO_W-1:0]} + {1'b0, c3[LO_W-1:0]};
        hi_sum = s3[ACC_W-1:LO_W] + c3[ACC_W-1:LO_W] + HI_W'(pend_q);
    end

    // accumulator and pending-carry registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            acc_q  <= {hi_sum, lo_sum[LO_W-1:0]};
            pend_q <= lo_sum[LO_W];
        end
    end

    // R6: two zero rows leave no new boundary carry behind
    a_r6_zero_rows_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (row_s == '0 && row_c == '0) |=> (pend_q == 1'b0));

    // R7: a clear empties both the sum and the pending carry
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0 && pend_q == 1'b0));
endmodule

// File: rtl/cfmac_top.sv
// Cutset-free pipelined MAC top. It gates the operands, builds partial
// products, reduces them to two rows and merges them into the split
// accumulator. A small sequencer runs one flush cycle after the last pair,
// shows the exact sum for one cycle, and clears it.
// Assumes in_last is meaningful only with in_valid.
module cfmac_top
    import cfmac_pkg::*;
#(
    parameter int OP_W  = cfmac_pkg::OP_W,
    parameter int ACC_W = cfmac_pkg::ACC_W,
    parameter int LO_W  = cfmac_pkg::LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             in_last,
    output logic [ACC_W-1:0] result,
    output logic             result_valid
);
    cf_state_e                 state_q;
    logic                      take;
    logic [OP_W-1:0]           a_g, b_g;
    logic [OP_W-1:0][ACC_W-1:0] pp;
    logic [ACC_W-1:0]          row_s, row_c;
    logic                      pend;

    // accept operands only while accumulating; zero them otherwise
    always_comb begin
        take = in_valid && (state_q == ST_ACC);
        a_g  = take ? op_a : '0;
        b_g  = take ? op_b : '0;
    end

    // sequencer: accumulate, then one flush cycle, then one result cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ACC;
        end else begin
            case (state_q)
                ST_ACC:   if (take && in_last) state_q <= ST_FLUSH;
                ST_FLUSH: state_q <= ST_DONE;
                default:  state_q <= ST_ACC;
            endcase
        end
    end

    cfmac_ppgen #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pp (
        .a  (a_g),
        .b  (b_g),
        .pp (pp)
    );

    cfmac_tree #(.OP_W(OP_W), .ACC_W(ACC_W)) u_tree (
        .pp    (pp),
        .row_s (row_s),
        .row_c (row_c)
    );

    cfmac_split_acc #(.ACC_W(ACC_W), .LO_W(LO_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_DONE),
        .row_s  (row_s),
        .row_c  (row_c),
        .acc_q  (result),
        .pend_q (pend)
    );

    assign result_valid = (state_q == ST_DONE);

    // R3: the result pulse lasts exactly one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R3: the flush cycle is followed directly by the result cycle
    a_r3_flush_then_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> result_valid);

    // R2: no carry is still pending while the result is shown
    a_r2_no_pending_at_result: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (pend == 1'b0));

    // R9: without in_valid the unit keeps accumulating
    a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && !in_valid) |=> (state_q == ST_ACC));
endmodule

// File: tb/cfmac_top_tb.sv
// Scoreboard bench: the driver pushes each stream's expected total and the
// monitor compares it against result at every result_valid pulse.
module cfmac_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic        in_last = 1'b0;
    logic [23:0] result;
    logic        result_valid;

    int          checks = 0;
    int          fails = 0;
    string       cur_tag = "R2";
    logic [23:0] exp_q[$];

    always #2 clk = ~clk;

    cfmac_top u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_a         (op_a),
        .op_b         (op_b),
        .in_last      (in_last),
        .result       (result),
        .result_valid (result_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive one cycle of inputs; returns at the next falling edge
    task automatic drive(input logic v, input logic [7:0] a, input logic [7:0] b, input logic l);
        in_valid = v; op_a = a; op_b = b; in_last = l;
        @(negedge clk);
    endtask

    // mode 0 random, 1 all ones, 2 extremes (0 or 255)
    task automatic run_seq(input int n, input int mode, input bit gaps, input bit stray);
        logic [23:0] sum = '0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] a, b;
            if (gaps && ($urandom % 4 == 0)) begin
                // R4 idle cycle with junk operands; R9 stray last while idle
                drive(1'b0, 8'($urandom), 8'($urandom), stray);
            end
            case (mode)
                1:       begin a = 8'hFF; b = 8'hFF; end
                2:       begin a = ($urandom % 2) ? 8'hFF : 8'h00;
                               b = ($urandom % 2) ? 8'hFF : 8'h00; end
                default: begin a = 8'($urandom); b = 8'($urandom); end
            endcase
            sum = sum + 24'(a) * 24'(b);
            if (i == n-1) exp_q.push_back(sum);
            drive(1'b1, a, b, i == n-1);
        end
        // R3 flush cycle: no pulse yet; R8 junk offered during it
        check("R3 flush-cycle pulse", 32'(result_valid), 32'd0);
        drive(1'b1, 8'hFF, 8'hFF, 1'b1);
        check("R3 result-cycle pulse", 32'(result_valid), 32'd1);
        drive(1'b1, 8'hFF, 8'hFF, 1'b1);
        check("R3 pulse end", 32'(result_valid), 32'd0);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // monitor: pop and compare on each result pulse
    always @(negedge clk) begin
        if (rst_n && result_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R9 actual=unexpected pulse expected=none");
            end else begin
                check(cur_tag, 32'(result), 32'(exp_q.pop_front()));
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 result after reset", 32'(result), 32'd0);
        check("R1 valid after reset", 32'(result_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid idle", 32'(result_valid), 32'd0);

        cur_tag = "R2 single pair";      run_seq(1, 0, 1'b0, 1'b0);
        cur_tag = "R6 all-ones 64";      run_seq(64, 1, 1'b0, 1'b0);
        cur_tag = "R7 back-to-back";     run_seq(1, 1, 1'b0, 1'b0);
        cur_tag = "R2 random 64";        run_seq(64, 0, 1'b0, 1'b0);
        cur_tag = "R6 extremes";         run_seq(40, 2, 1'b1, 1'b0);
        for (int k = 0; k < 30; k++) begin
            cur_tag = "R4 R9 random gaps";
            run_seq(1 + int'($urandom % 64), int'($urandom % 3), 1'b1, 1'b1);
        end
        cur_tag = "R5 wrap 300 all-ones"; run_seq(300, 1, 1'b1, 1'b0);
        cur_tag = "R8 after wrap";       run_seq(3, 0, 1'b0, 1'b0);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule